// File: doc/BRIEF.md
# Segmented Successive-Approximation Stage Sequencer

This block sequences the coarse stage of a two-stage pipelined successive-approximation converter. A start request opens a conversion frame of twelve clocks. The frame starts with a two-clock input-sampling phase. Seven one-clock trials follow, most significant bit first. Each trial reads a single comparator decision. One settling clock then forms the residue, and a two-clock residue-transfer phase hands the residue to the fine stage. So the clock runs at twelve times the sample rate.

The capacitor array has two segments. The three upper code bits leave the block as seven unary switch lines in thermometer form. The four lower code bits drive binary-weighted switches directly. A one-clock strobe marks the cycle in which the seven result bits become final. The result stays on its port until the next conversion completes. A start that arrives in the last transfer clock chains a new frame with no idle gap. A synchronous reset puts the switches back at midscale.

Top module: `seg_sar_sequencer`

## Requirements
- R1: While reset is high and after it is released, the unary lines read 0001111 (lines 0 to 3 high), the binary lines read 0000, the result reads 0, and the strobe and both phase outputs are low. The array therefore presents midscale code 64.
- R2: A start seen on a clock edge while the block is idle raises the sampling phase for exactly the two cycles after that edge.
- R3: The seven trials occupy frame cycles 2 to 8 (cycle 0 is the first sampling cycle). The first trial presents code 64. At the end of a trial the bit under test stays set if the comparator input is 1 (the input is at or above the array level) and is cleared if it is 0. The next lower bit is then set for the following trial.
- R4: Unary line j (0..6) is high exactly when the upper three code bits, read as an unsigned value, exceed j. The binary lines carry code bits 3..0, with line 0 as the least significant bit. The array level is 16 times the number of high unary lines plus the binary value. Both groups change on the same clock edge.
- R5: The strobe is high for exactly one cycle, frame cycle 9. In that cycle the result port shows the 7-bit code with bit 6 as the most significant bit. The result holds its value until the next strobe.
- R6: The transfer phase is high in frame cycles 10 and 11 only. It is never high together with the sampling phase.
- R7: A start during frame cycles 0 to 10 has no effect. The frame keeps its timing and its result.
- R8: A start in frame cycle 11 begins a new frame on the next edge. Sampling rises directly after the transfer phase, and the array returns to code 64.
- R9: The comparator input is ignored outside trial cycles. The array holds code 64 through sampling and holds the final code through settling and transfer.
- R10: A reset during a frame aborts it and restores the state of R1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, twelve cycles per sample |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to open a conversion frame |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above the array level |
| unary_sw | output | 7 | Thermometer switch lines of the upper segment |
| binary_sw | output | 4 | Binary switch lines of the lower segment |
| result | output | 7 | Final code of the last conversion |
| result_vld | output | 1 | One-cycle strobe when the result is final |
| sample_ph | output | 1 | Input-sampling phase |
| xfer_ph | output | 1 | Residue-transfer phase |

## Verification
Two events can fall in the same cycle: the end of the residue transfer and the start of the next sample. This happens when a start arrives in frame cycle 11. The bench triggers it by chaining half of a full sweep over all 128 input codes. It judges the result by checking that sampling rises straight after the transfer phase, that the array is back at midscale, and that the chained conversion still resolves its own code. A start placed in the middle of the trials tests the opposite case, where the start must be ignored. Comparator noise driven outside the trial cycles must leave the array level unchanged.

// File: rtl/seg_sar_pkg.sv
package seg_sar_pkg;

  // Which part of the frame the sequencer is in.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_TRIAL,
    PH_SETTLE,
    PH_XFER
  } frame_seg_e;

  localparam int unsigned DEF_BITS   = 7;
  localparam int unsigned DEF_SEG    = 3;
  localparam int unsigned DEF_SAMPLE = 2;
  localparam int unsigned DEF_XFER   = 2;

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
  import seg_sar_pkg::*;
#(
  parameter int unsigned NBITS      = DEF_BITS,
  parameter int unsigned SAMPLE_CYC = DEF_SAMPLE,
  parameter int unsigned XFER_CYC   = DEF_XFER,
  localparam int unsigned FRAME     = SAMPLE_CYC + NBITS + 1 + XFER_CYC,
  localparam int unsigned CNT_W     = $clog2(FRAME),
  localparam int unsigned IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             go,
  output frame_seg_e       seg,
  output logic [IDX_W-1:0] idx,
  output logic             sample_ph,
  output logic             xfer_ph
);

  localparam int unsigned TRIAL_LO  = SAMPLE_CYC;
  localparam int unsigned SETTLE_AT = SAMPLE_CYC + NBITS;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             last;

  assign last = busy_q && (cnt_q == CNT_W'(FRAME - 1));
  assign go   = start && (!busy_q || last);

  always_comb begin
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && !last) begin
      busy_d = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end else begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_comb begin
    if (!busy_q)                                seg = PH_IDLE;
    else if (int'(cnt_q) < TRIAL_LO)            seg = PH_SAMPLE;
    else if (int'(cnt_q) < SETTLE_AT)           seg = PH_TRIAL;
    else if (int'(cnt_q) < FRAME - XFER_CYC)    seg = PH_SETTLE;
    else                                        seg = PH_XFER;
  end

  assign idx = IDX_W'(int'(NBITS - 1 + TRIAL_LO) - int'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      sample_ph <= 1'b0;
      xfer_ph   <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      sample_ph <= busy_d && (int'(cnt_d) < SAMPLE_CYC);
      xfer_ph   <= busy_d && (int'(cnt_d) >= FRAME - XFER_CYC);
    end
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import seg_sar_pkg::*;
#(
  parameter int unsigned NBITS = DEF_BITS,
  localparam int unsigned IDX_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_hi,
  input  logic             go,
  input  frame_seg_e       seg,
  input  logic [IDX_W-1:0] idx,
  output logic [NBITS-1:0] code_d,
  output logic [NBITS-1:0] code_q,
  output logic [NBITS-1:0] result_q,
  output logic             done_q
);

  localparam logic [NBITS-1:0] MID = NBITS'(1) << (NBITS - 1);

  logic final_trial;

  assign final_trial = !go && (seg == PH_TRIAL) && (idx == '0);

  // Decide the bit under test and pre-set the next lower one.
  always_comb begin
    code_d = code_q;
    if (go) begin
      code_d = MID;
    end else if (seg == PH_TRIAL) begin
      code_d[idx] = cmp_hi;
      if (idx != '0) code_d[idx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= MID;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      done_q <= final_trial;
      if (final_trial) result_q <= code_d;
    end
  end

endmodule

// File: rtl/sar_therm_reg.sv
module sar_therm_reg #(
  parameter int unsigned SEG_BITS = 3,
  localparam int unsigned LINES   = (1 << SEG_BITS) - 1,
  localparam int unsigned HALF    = 1 << (SEG_BITS - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEG_BITS-1:0] seg_val,
  output logic [LINES-1:0]    lines_q
);

  for (genvar j = 0; j < LINES; j++) begin : g_line
    localparam logic RST_VAL = (j < HALF);
    always_ff @(posedge clk) begin
      if (rst) lines_q[j] <= RST_VAL;
      else     lines_q[j] <= (seg_val > SEG_BITS'(j));
    end
  end

endmodule

// File: rtl/seg_sar_sequencer.sv
module seg_sar_sequencer
  import seg_sar_pkg::*;
#(
  parameter int unsigned NBITS      = DEF_BITS,
  parameter int unsigned SEG_BITS   = DEF_SEG,
  parameter int unsigned SAMPLE_CYC = DEF_SAMPLE,
  parameter int unsigned XFER_CYC   = DEF_XFER
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          cmp_hi,
  output logic [(1 << SEG_BITS) - 2:0]  unary_sw,
  output logic [NBITS-SEG_BITS-1:0]     binary_sw,
  output logic [NBITS-1:0]              result,
  output logic                          result_vld,
  output logic                          sample_ph,
  output logic                          xfer_ph
);

  localparam int unsigned IDX_W = $clog2(NBITS);
  localparam int unsigned LOW_W = NBITS - SEG_BITS;

  logic             go;
  frame_seg_e       seg;
  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] code_d, code_q;

  sar_frame_timer #(
    .NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .XFER_CYC(XFER_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start), .go(go), .seg(seg), .idx(idx),
    .sample_ph(sample_ph), .xfer_ph(xfer_ph)
  );

  sar_trial_reg #(.NBITS(NBITS)) u_trial (
    .clk(clk), .rst(rst), .cmp_hi(cmp_hi), .go(go), .seg(seg), .idx(idx),
    .code_d(code_d), .code_q(code_q), .result_q(result), .done_q(result_vld)
  );

  sar_therm_reg #(.SEG_BITS(SEG_BITS)) u_therm (
    .clk(clk), .rst(rst), .seg_val(code_d[NBITS-1 -: SEG_BITS]),
    .lines_q(unary_sw)
  );

  assign binary_sw = code_q[LOW_W-1:0];

endmodule

// File: rtl/seg_sar_checker.sv
module seg_sar_checker #(
  parameter int unsigned NBITS    = 7,
  parameter int unsigned SEG_BITS = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic [(1 << SEG_BITS) - 2:0] unary_sw,
  input logic [NBITS-SEG_BITS-1:0]    binary_sw,
  input logic [NBITS-1:0]             result,
  input logic                         result_vld,
  input logic                         sample_ph,
  input logic                         xfer_ph
);

  localparam int unsigned UL = (1 << SEG_BITS) - 1;

  logic [UL:0] u_ext;
  assign u_ext = {1'b0, unary_sw};

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_ph && xfer_ph)); // R6
  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (((u_ext + 1'b1) & u_ext) == '0)); // R4
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> !result_vld); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !result_vld |-> $stable(result)); // R5
  AST_SAMPLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_ph) |=> sample_ph); // R2
  AST_SAMPLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (sample_ph && $past(sample_ph)) |=> !sample_ph); // R2
  AST_XFER_AFTER_VLD: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> xfer_ph); // R6
  AST_XFER_STILL: assert property (@(posedge clk) disable iff (rst)
    xfer_ph |-> ($stable(binary_sw) && $stable(unary_sw))); // R9

endmodule

bind seg_sar_sequencer seg_sar_checker #(.NBITS(NBITS), .SEG_BITS(SEG_BITS)) u_chk (
  .clk(clk), .rst(rst), .unary_sw(unary_sw), .binary_sw(binary_sw),
  .result(result), .result_vld(result_vld), .sample_ph(sample_ph),
  .xfer_ph(xfer_ph)
);

// File: tb/seg_sar_sequencer_bench.sv
module seg_sar_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cmp_hi = 1'b0;
  logic [6:0] unary_sw;
  logic [3:0] binary_sw;
  logic [6:0] result;
  logic       result_vld, sample_ph, xfer_ph;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit armed = 1'b0;

  always #2 clk = ~clk;

  seg_sar_sequencer u_seg_sar_sequencer (
    .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
    .unary_sw(unary_sw), .binary_sw(binary_sw), .result(result),
    .result_vld(result_vld), .sample_ph(sample_ph), .xfer_ph(xfer_ph)
  );

  function automatic int ucount();
    int n = 0;
    for (int j = 0; j < 7; j++) n += unary_sw[j];
    return n;
  endfunction

  function automatic int dac_now();
    return 16 * ucount() + int'(binary_sw);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Reset values (R1 / R10).
  task automatic chk_rest(input string req);
    chk(unary_sw == 7'b0001111, req, unary_sw, 15);
    chk(binary_sw == 4'd0, req, binary_sw, 0);
    chk(result == 7'd0, req, result, 0);
    chk({result_vld, sample_ph, xfer_ph} == 3'b000, req,
        {result_vld, sample_ph, xfer_ph}, 0);
  endtask

  // One full frame; caller stands at a negedge.
  task automatic conv(input int vin, input bit chain, input bit poke, input bit pre);
    if (!pre) begin
      start = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    for (int i = 0; i < 12; i++) begin
      int d = dac_now();
      start = 1'b0;
      chk(sample_ph == (i < 2), "R2 sample phase", sample_ph, i < 2);
      chk(xfer_ph == (i >= 10), "R6 transfer phase", xfer_ph, i >= 10);
      chk(result_vld == (i == 9), "R5 strobe", result_vld, i == 9);
      chk(unary_sw == 7'((1 << ucount()) - 1), "R4 thermometer", unary_sw,
          (1 << ucount()) - 1);
      if (i < 2) chk(d == 64, "R9 midscale in sampling", d, 64);
      if (i >= 2 && i <= 8) begin
        int b = 8 - i;
        int e = (vin & ~((1 << (b + 1)) - 1)) | (1 << b);
        chk(d == e, "R3 trial code", d, e);
      end
      if (i >= 9) begin
        chk(d == vin, "R9 final code held", d, vin);
        chk(int'(result) == vin, "R5 result", result, vin);
      end
      if (i >= 2 && i <= 8) cmp_hi = (vin >= d);
      else                  cmp_hi = i[0];
      if (poke && i == 5) start = 1'b1;  // R7 ignored start
      if (chain && i == 11) start = 1'b1; // R8 chained start
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    if (chain) begin
      chk(sample_ph && !xfer_ph, "R8 chained sampling", sample_ph, 1);
      chk(dac_now() == 64, "R8 chained midscale", dac_now(), 64);
    end else begin
      chk(!sample_ph && !xfer_ph, "R7 frame end idle", {sample_ph, xfer_ph}, 0);
      chk(int'(result) == vin, "R5 result held", result, vin);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_rest("R1 in reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_rest("R1 after release");
    for (int v = 0; v < 128; v++) begin
      bit ch = v[0];
      conv(v, ch, v[1], armed);
      armed = ch;
    end
    conv(85, 1'b0, 1'b0, armed);
    // R10 reset mid-frame
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    cmp_hi = 1'b0;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_rest("R10 reset mid-frame");
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_rest("R10 stays idle");
    conv(42, 1'b0, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule